// File: doc/BRIEF.md
# Fan PWM Speed Command Decoder

This block sits between the four-wire fan connector's control line and the speed regulator. It measures the duty cycle of the incoming control PWM, which nominally runs at 21 to 28 kHz and carries a 0 to 100 % command. At a fixed refresh interval it publishes a whole-number percentage with a one-cycle strobe. The regulator maps that percentage to a target speed.

The raw pin passes through a synchronizer. High time and period are then counted for every complete input cycle, and the counts are summed over the refresh window. The window ratio is turned into a percentage by a short sequential divider, and a minimum-speed policy is applied to the result. The policy is chosen at elaboration. One choice clamps every low command, including zero, to the minimum speed. The other clamps non-zero low commands to the minimum but turns a window with no high time at all into a stop request. A line that shows no edge for longer than a stall limit is read from its level: a floating, pulled-high line counts as 100 % and a line held low counts as 0 %.

The default parameters assume a 50 MHz clock, giving a 128 ms window (6,400,000 cycles), a stall limit of 12,000 cycles (about five input periods), and a minimum of 20 %.

Top module: `fan_pwm_cmd_decoder`

## Requirements
- R1: During and right after reset, `duty_pct` reads 100, `stop_req` reads 0 and `cmd_valid` reads 0.
- R2: `cmd_valid` is a single-cycle pulse that repeats every `WIN_CYC` clock cycles.
- R3: For a steady input with high time H and period P cycles (0 < H < P, P below the stall limit), the published raw percentage is floor(100·H/P). When that value is at least `MIN_PCT`, it is output unchanged.
- R4: With `POLICY` = FLOOR_AT_MIN (encoding 0), any measured value below `MIN_PCT`, zero included, is output as `MIN_PCT`, and `stop_req` stays 0.
- R5: With `POLICY` = STOP_AT_ZERO (encoding 1), a window that contains some high time but measures below `MIN_PCT` (a raw floor of 0 included) is output as `MIN_PCT` with `stop_req` 0.
- R6: With `POLICY` = STOP_AT_ZERO, a window with no high time is output as `duty_pct` 0 with `stop_req` 1. `stop_req` is never 1 together with a non-zero duty.
- R7: A line held high with no edge for more than `STALL_CYC` cycles at the end of a window is published as 100 under both policies.
- R8: A line held low with no edge for more than `STALL_CYC` cycles is published as 0 % before the policy: `MIN_PCT` under FLOOR_AT_MIN, and 0 with a stop request under STOP_AT_ZERO.
- R9: `duty_pct` and `stop_req` change only in the cycle in which `cmd_valid` is 1. Between strobes they hold, whatever the input does.
- R10: `duty_pct` never exceeds 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_pwm_in | input | 1 | Raw control PWM pin, asynchronous |
| duty_pct | output | 7 | Published speed command in percent after the policy |
| cmd_valid | output | 1 | One-cycle strobe marking a new command |
| stop_req | output | 1 | Motor stop request (STOP_AT_ZERO policy only) |

## Verification
The assertions assume the input period stays well below the stall limit, and the stall limit well below the window. Under those conditions every window closes with either a valid cycle sum or a clean level reading, and the divider is idle whenever a new snapshot arrives. The stimulus draws periods of 40 to 149 cycles against a 400-cycle stall limit and a 2000-cycle window. It changes the pattern only right after a strobe and judges only the third window after a change, so no window mixes two patterns. Directed cases hold the line high and low beyond the stall limit and place duties at and just around the threshold.

// File: rtl/fpd_pkg.sv
// Package: shared types and constants of the fan PWM command decoder.
// Assumes percentages fit in 7 bits (0..100).
package fpd_pkg;
    // Policy for commands below the minimum duty.
    typedef enum logic {
        FLOOR_AT_MIN = 1'b0,
        STOP_AT_ZERO = 1'b1
    } low_policy_e;

    localparam int PCT_W    = 7;
    localparam int FULL_PCT = 100;
endpackage

// File: rtl/fpd_sync_edge.sv
// Module: fpd_sync_edge
// Brings the asynchronous control pin into the clock domain through a flop
// chain and flags rising and falling edges of the synchronized level.
// Assumes STAGES >= 2. The chain resets high to match a pulled-up idle line.
module fpd_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              last;

    // Shift the raw pin through the synchronizer and keep one delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
            last  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], pin_raw};
            last  <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
    assign rise  = level & ~last;
    assign fall  = ~level & last;
endmodule

// File: rtl/fpd_cycle_meter.sv
// Module: fpd_cycle_meter
// Counts high time and period of every complete input cycle (rising edge to
// rising edge), sums them over a window of WIN_CYC clocks, and at the window
// end hands one snapshot to the divider. If no edge was seen for STALL_CYC
// clocks, or no full cycle ended in the window, the snapshot encodes the line
// level instead (1/1 for high, 0/1 for low).
// Assumes STALL_CYC < WIN_CYC and AW wide enough for WIN_CYC + STALL_CYC.
module fpd_cycle_meter #(
    parameter int WIN_CYC   = 6_400_000,
    parameter int STALL_CYC = 12_000,
    parameter int AW        = 23
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          level,
    input  logic          rise,
    input  logic          fall,
    output logic          snap_valid,
    output logic [AW-1:0] snap_high,
    output logic [AW-1:0] snap_period,
    output logic          snap_zero
);
    localparam int CW = $clog2(STALL_CYC + 2);
    localparam int WW = $clog2(WIN_CYC + 1);
    localparam logic [CW-1:0] C_SAT   = CW'(STALL_CYC + 1);
    localparam logic [CW-1:0] C_STALL = CW'(STALL_CYC);
    localparam logic [WW-1:0] W_LAST  = WW'(WIN_CYC - 1);

    logic [CW-1:0] quiet_cnt;
    logic [CW-1:0] hi_cnt;
    logic [CW-1:0] per_cnt;
    logic          armed;
    logic [WW-1:0] win_cnt;
    logic [AW-1:0] acc_hi;
    logic [AW-1:0] acc_per;
    logic [AW-1:0] acc_hi_nx;
    logic [AW-1:0] acc_per_nx;
    logic          stalled;
    logic          win_end;
    logic          take;

    assign stalled = (quiet_cnt == C_STALL);
    assign win_end = (win_cnt == W_LAST);
    assign take    = rise & armed;

    // Count clocks since the last edge of either polarity, saturating at the stall limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            quiet_cnt <= '0;
        else if (rise | fall)
            quiet_cnt <= '0;
        else if (!stalled)
            quiet_cnt <= quiet_cnt + 1'b1;
    end

    // Arm on a rising edge so that only cycles with a known start are summed.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b0;
        else if (rise)
            armed <= 1'b1;
        else if (stalled)
            armed <= 1'b0;
    end

    // Per-cycle high and period counters, restarted on every rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt  <= '0;
            per_cnt <= '0;
        end else if (rise) begin
            hi_cnt  <= CW'(1);
            per_cnt <= CW'(1);
        end else begin
            if (level && hi_cnt != C_SAT)
                hi_cnt <= hi_cnt + 1'b1;
            if (per_cnt != C_SAT)
                per_cnt <= per_cnt + 1'b1;
        end
    end

    assign acc_hi_nx  = acc_hi  + (take ? AW'(hi_cnt)  : '0);
    assign acc_per_nx = acc_per + (take ? AW'(per_cnt) : '0);

    // Free-running window counter that sets the refresh interval.
    always_ff @(posedge clk) begin
        if (!rst_n)
            win_cnt <= '0;
        else if (win_end)
            win_cnt <= '0;
        else
            win_cnt <= win_cnt + 1'b1;
    end

    // Window accumulators, cleared when a snapshot is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_hi  <= '0;
            acc_per <= '0;
        end else if (win_end) begin
            acc_hi  <= '0;
            acc_per <= '0;
        end else begin
            acc_hi  <= acc_hi_nx;
            acc_per <= acc_per_nx;
        end
    end

    // Snapshot at window end: measured sums, or the level rule for a quiet line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_valid  <= 1'b0;
            snap_high   <= '0;
            snap_period <= AW'(1);
            snap_zero   <= 1'b0;
        end else begin
            snap_valid <= win_end;
            if (win_end) begin
                if (stalled || acc_per_nx == '0) begin
                    snap_high   <= level ? AW'(1) : '0;
                    snap_period <= AW'(1);
                    snap_zero   <= ~level;
                end else begin
                    snap_high   <= acc_hi_nx;
                    snap_period <= acc_per_nx;
                    snap_zero   <= (acc_hi_nx == '0);
                end
            end
        end
    end

    // High time can never exceed the period it belongs to.
    assert_acc_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_hi <= acc_per);
    // The divider never receives a zero divisor.
    assert_snap_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        snap_valid |-> snap_period != '0);
    // A quiet line drops the cycle measurement.
    assert_stall_disarms_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stalled && !rise) |=> !armed);
endmodule

// File: rtl/fpd_ratio_div.sv
// Module: fpd_ratio_div
// Sequential restoring divider computing floor(100 * num_high / den), one
// quotient bit per clock, QW clocks per result, with done pulsed afterwards.
// Assumes num_high <= den, so the quotient is at most 100, and den != 0.
module fpd_ratio_div #(
    parameter int AW = 23,
    parameter int QW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] num_high,
    input  logic [AW-1:0] den,
    output logic          done,
    output logic [QW-1:0] quot
);
    localparam int NW = AW + QW;
    localparam int IW = $clog2(QW);
    localparam logic [NW-1:0] SCALE = NW'(100);

    logic [NW-1:0] rem;
    logic [NW-1:0] dsh;
    logic [AW-1:0] den_q;
    logic [IW-1:0] idx;
    logic          busy;

    assign dsh = NW'(den_q) << idx;

    // Load on start, then subtract shifted divisor from the top bit downward.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            rem   <= '0;
            den_q <= '0;
            idx   <= '0;
            quot  <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem   <= NW'(num_high) * SCALE;
                den_q <= den;
                idx   <= IW'(QW - 1);
                quot  <= '0;
                busy  <= 1'b1;
            end else if (busy) begin
                if (rem >= dsh) begin
                    rem       <= rem - dsh;
                    quot[idx] <= 1'b1;
                end
                if (idx == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    idx <= idx - 1'b1;
                end
            end
        end
    end

    // A new window never arrives while a division is still running.
    assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
    // A finished quotient is a valid percentage.
    assert_quot_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> quot <= QW'(100));
endmodule

// File: rtl/fan_pwm_cmd_decoder.sv
// Module: fan_pwm_cmd_decoder (top)
// Turns the fan control PWM into a percent speed command published once per
// window, applying the elaboration-time minimum-speed policy.
// Assumes input periods well below STALL_CYC and STALL_CYC well below WIN_CYC.
module fan_pwm_cmd_decoder #(
    parameter int                  WIN_CYC     = 6_400_000,
    parameter int                  STALL_CYC   = 12_000,
    parameter int                  MIN_PCT     = 20,
    parameter int                  SYNC_STAGES = 2,
    parameter fpd_pkg::low_policy_e POLICY     = fpd_pkg::FLOOR_AT_MIN
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ctrl_pwm_in,
    output logic [fpd_pkg::PCT_W-1:0]   duty_pct,
    output logic                        cmd_valid,
    output logic                        stop_req
);
    localparam int PW = fpd_pkg::PCT_W;
    localparam int AW = $clog2(WIN_CYC + STALL_CYC + 2);
    localparam int GW = $clog2(WIN_CYC + 2);
    localparam logic [PW-1:0] MIN_Q  = PW'(MIN_PCT);
    localparam logic [PW-1:0] FULL_Q = PW'(fpd_pkg::FULL_PCT);
    localparam logic [GW-1:0] G_SAT  = {GW{1'b1}};

    logic          lvl, rise, fall;
    logic          snap_valid, snap_zero;
    logic [AW-1:0] snap_high, snap_period;
    logic          div_done;
    logic [PW-1:0] quot;
    logic          zero_hold;
    logic [PW-1:0] pol_pct;
    logic          pol_stop;

    fpd_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_raw(ctrl_pwm_in),
        .level(lvl), .rise(rise), .fall(fall)
    );

    fpd_cycle_meter #(.WIN_CYC(WIN_CYC), .STALL_CYC(STALL_CYC), .AW(AW)) u_meter (
        .clk(clk), .rst_n(rst_n), .level(lvl), .rise(rise), .fall(fall),
        .snap_valid(snap_valid), .snap_high(snap_high),
        .snap_period(snap_period), .snap_zero(snap_zero)
    );

    fpd_ratio_div #(.AW(AW), .QW(PW)) u_div (
        .clk(clk), .rst_n(rst_n), .start(snap_valid),
        .num_high(snap_high), .den(snap_period),
        .done(div_done), .quot(quot)
    );

    // Keep the no-high-time flag of the window being divided.
    always_ff @(posedge clk) begin
        if (!rst_n)
            zero_hold <= 1'b0;
        else if (snap_valid)
            zero_hold <= snap_zero;
    end

    // Minimum-speed policy; the variant is fixed at elaboration.
    generate
        if (POLICY == fpd_pkg::STOP_AT_ZERO) begin : g_stop
            always_comb begin
                if (zero_hold) begin
                    pol_pct  = '0;
                    pol_stop = 1'b1;
                end else if (quot < MIN_Q) begin
                    pol_pct  = MIN_Q;
                    pol_stop = 1'b0;
                end else begin
                    pol_pct  = quot;
                    pol_stop = 1'b0;
                end
            end
        end else begin : g_floor
            always_comb begin
                pol_pct  = (quot < MIN_Q) ? MIN_Q : quot;
                pol_stop = 1'b0;
            end
        end
    endgenerate

    // Publish the command registers and the strobe together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_pct  <= FULL_Q;
            stop_req  <= 1'b0;
            cmd_valid <= 1'b0;
        end else begin
            cmd_valid <= div_done;
            if (div_done) begin
                duty_pct <= pol_pct;
                stop_req <= pol_stop;
            end
        end
    end

    // Checker state: clocks since the previous strobe.
    logic [GW-1:0] gap_cnt;
    logic          gap_seen;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt  <= '0;
            gap_seen <= 1'b0;
        end else if (cmd_valid) begin
            gap_cnt  <= GW'(1);
            gap_seen <= 1'b1;
        end else if (gap_cnt != G_SAT) begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

    assert_strobe_interval_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && gap_seen) |-> gap_cnt == GW'(WIN_CYC));
    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);
    assert_hold_between_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |-> ($stable(duty_pct) && $stable(stop_req)));
    assert_pct_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        duty_pct <= FULL_Q);

    generate
        if (POLICY == fpd_pkg::STOP_AT_ZERO) begin : g_chk_stop
            assert_stop_only_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
                stop_req |-> duty_pct == '0);
            assert_low_band_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (cmd_valid && !stop_req) |-> duty_pct >= MIN_Q);
        end else begin : g_chk_floor
            assert_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
                cmd_valid |-> (duty_pct >= MIN_Q && !stop_req));
        end
    endgenerate
endmodule

// File: tb/tb_fan_pwm_cmd_decoder.sv
// Bench: drives one control pin into two decoders, one per policy, and checks
// the published commands against values computed from the requirements.
module tb_fan_pwm_cmd_decoder;
    localparam int WIN   = 2000;
    localparam int STALL = 400;
    localparam int MINP  = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin = 1'b1;
    logic [6:0] duty_a, duty_b;
    logic       valid_a, valid_b, stop_a, stop_b;

    int n_chk = 0;
    int n_fail = 0;
    int gen_p = 100;
    int gen_h = 100;
    int gap_cnt = 0;
    int last_gap = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    fan_pwm_cmd_decoder #(.WIN_CYC(WIN), .STALL_CYC(STALL), .MIN_PCT(MINP),
                          .POLICY(fpd_pkg::FLOOR_AT_MIN)) dut (
        .clk(clk), .rst_n(rst_n), .ctrl_pwm_in(pin),
        .duty_pct(duty_a), .cmd_valid(valid_a), .stop_req(stop_a));

    fan_pwm_cmd_decoder #(.WIN_CYC(WIN), .STALL_CYC(STALL), .MIN_PCT(MINP),
                          .POLICY(fpd_pkg::STOP_AT_ZERO)) dut_stop (
        .clk(clk), .rst_n(rst_n), .ctrl_pwm_in(pin),
        .duty_pct(duty_b), .cmd_valid(valid_b), .stop_req(stop_b));

    // Pin generator: h == 0 holds low, h >= p holds high, else one PWM cycle.
    initial begin
        forever begin
            if (gen_h == 0) begin
                pin = 1'b0;
                @(negedge clk);
            end else if (gen_h >= gen_p) begin
                pin = 1'b1;
                @(negedge clk);
            end else begin
                pin = 1'b1;
                repeat (gen_h) @(negedge clk);
                pin = 1'b0;
                repeat (gen_p - gen_h) @(negedge clk);
            end
        end
    end

    // Strobe spacing observer.
    always @(negedge clk) begin
        if (!rst_n) begin
            gap_cnt <= 0;
        end else if (valid_a) begin
            last_gap <= gap_cnt;
            gap_cnt  <= 1;
        end else begin
            gap_cnt <= gap_cnt + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int raw_pct(input int p, input int h);
        if (h <= 0) return 0;
        if (h >= p) return 100;
        return (100 * h) / p;
    endfunction

    function automatic int exp_floor(input int p, input int h);
        int r = raw_pct(p, h);
        return (r < MINP) ? MINP : r;
    endfunction

    function automatic int exp_stop_pct(input int p, input int h);
        int r = raw_pct(p, h);
        if (h <= 0) return 0;
        return (r < MINP) ? MINP : r;
    endfunction

    task automatic wait_strobe();
        @(negedge clk);
        while (!valid_a) @(negedge clk);
    endtask

    // One case: change the pattern just after a strobe, check the hold, then judge window three.
    task automatic run_case(input int p, input int h, input string tag_a, input string tag_b);
        int pa = duty_a;
        int sa = stop_a;
        int pb = duty_b;
        int sb = stop_b;
        gen_p = p;
        gen_h = h;
        repeat (WIN - 100) @(negedge clk);
        chk("R9 hold duty floor-mode", duty_a, pa);
        chk("R9 hold stop floor-mode", stop_a, sa);
        chk("R9 hold duty stop-mode", duty_b, pb);
        chk("R9 hold stop stop-mode", stop_b, sb);
        wait_strobe();
        wait_strobe();
        wait_strobe();
        chk("R2 strobes aligned", valid_b, 1);
        chk({tag_a, " duty floor-mode"}, duty_a, exp_floor(p, h));
        chk({tag_a, " stop floor-mode"}, stop_a, 0);
        chk({tag_b, " duty stop-mode"}, duty_b, exp_stop_pct(p, h));
        chk({tag_b, " stop stop-mode"}, stop_b, (h <= 0) ? 1 : 0);
        chk("R10 duty within 100", (duty_a <= 100 && duty_b <= 100) ? 1 : 0, 1);
        @(negedge clk);
        chk("R2 strobe one cycle", valid_a, 0);
        chk("R2 strobe interval", last_gap, WIN);
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7231));
        repeat (4) @(negedge clk);
        chk("R1 reset duty floor-mode", duty_a, 100);
        chk("R1 reset stop floor-mode", stop_a, 0);
        chk("R1 reset valid", valid_a, 0);
        chk("R1 reset duty stop-mode", duty_b, 100);
        chk("R1 reset stop stop-mode", stop_b, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset duty", duty_a, 100);
        chk("R1 after reset valid", valid_b, 0);
        wait_strobe();

        run_case(100, 50,  "R3", "R3");
        run_case(100, 20,  "R3", "R3");
        run_case(100, 19,  "R4", "R5");
        run_case(149, 1,   "R4", "R5");   // raw floor 0 but non-zero high time
        run_case(120, 119, "R3", "R3");   // 99 %
        run_case(100, 100, "R7", "R7");   // held high past the stall limit
        run_case(100, 0,   "R8", "R6");   // held low past the stall limit
        run_case(80, 60,   "R3", "R3");   // recovery from a stalled line

        for (int i = 0; i < 9; i++) begin
            int p = 40 + int'($urandom % 110);
            int h = 1 + int'($urandom % (p - 1));
            if (raw_pct(p, h) < MINP)
                run_case(p, h, "R4", "R5");
            else
                run_case(p, h, "R3", "R3");
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule